// File: doc/BRIEF.md
# Dual-Addressing SPI Register Slave

This block is the host-facing serial port of a register-mapped peripheral. An external controller drives a four-wire SPI link in mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge) at up to 1 MHz. The block recovers commands from that link and turns them into single-cycle accesses on a synchronous memory port, behind which sit the register file and the FIFO buffers.

There are two address spaces. A one-byte command reaches the 64-entry short space. A two-byte command reaches the 1024-entry long space. The long space holds a transmit buffer window at address 0x000, a block of long registers at 0x200 and a receive buffer window at 0x300. Long commands stream: after the command, every further data byte goes to or comes from the next address until chip select is released. This lets a buffer be filled or drained in a single frame.

The SPI pins are sampled by the system clock, which runs much faster than the link. The block therefore needs no second clock domain.

Top module: `dspi_top`

## Requirements
- R1: A command byte with bit 7 clear is a short command. Its bits 6..1 give the short address and its bit 0 clear marks a read. The content of that address is shifted out MSB first during the second byte of the frame. MISO is 0 during the command byte.
- R2: A short command with bit 0 set is a write. The second byte of the frame is stored at the short address. Any further bytes in the same frame cause no memory access.
- R3: A command byte with bit 7 set starts a 16-bit long command. Frame bits 14..5 carry the 10-bit address and bit 4 set marks a write; bits 3..0 are ignored. For a long read, data appears in the third byte.
- R4: After a long write command, each data byte is stored at the next consecutive address. The address wraps from 0x3FF to 0x000.
- R5: After a long read command, each further byte clocked returns the content of the next consecutive address, with the same wrap.
- R6: Chip select going high discards any partial byte and returns the decoder to expecting a command byte. The discarded bits cause no memory access.
- R7: The implemented long addresses are 0x000..0x07F, 0x200..0x23F and 0x300..0x38F. All 64 short addresses are implemented. A read of any other long address returns 0x00, and a write to one produces no memory access.
- R8: MISO changes only after a falling SCLK edge and is stable when the host samples it at the next rising edge. MISO is 0 while chip select is high and after reset.
- R9: The memory port asserts mem_en for exactly one clock per access. Read data is taken from mem_rdata on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sclk | input | 1 | SPI serial clock from the host, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low, frames a transaction |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| mem_en | output | 1 | One-cycle access strobe to the storage |
| mem_we | output | 1 | Write when high, read when low; valid with mem_en |
| mem_long | output | 1 | 1 selects the long space, 0 the short space |
| mem_addr | output | 10 | Access address; upper four bits are 0 for short accesses |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one clock after a read strobe |

## Verification
The bench targets these corner cases:
- A long burst that crosses from the transmit window into the unmapped gap. A design with a wrong window edge would strobe the memory or return stored data instead of zero.
- A write burst that starts at 0x3FF. A design without a 10-bit wrap would write out of range instead of at 0x000.
- A short write followed by a stray third byte. A design that auto-increments short commands would produce an unexpected write.
- Frames cut off mid-byte, both in the first byte and in the second byte of a long command. A decoder that keeps its state would misread the next short command as a long one.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  localparam int BYTE_W   = 8;
  localparam int SHORT_AW = 6;
  localparam int LONG_AW  = 10;
  localparam int CNT_W    = $clog2(BYTE_W);
  localparam int HI_W     = LONG_AW - 3;

  typedef enum logic [1:0] {
    PH_CMD0,
    PH_CMD1,
    PH_DATA,
    PH_DONE
  } dspi_phase_e;

  typedef struct packed {
    logic                we;
    logic                long_sel;
    logic [LONG_AW-1:0]  addr;
    logic [BYTE_W-1:0]   wdata;
  } dspi_access_t;
endpackage

// File: rtl/dspi_pin_sync.sv
module dspi_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sel_o,
  output logic rise_o,
  output logic fall_o,
  output logic mosi_o
);
  // bit order: {sclk, cs_n, mosi}
  logic [2:0] stage1_q, stage2_q;
  logic       sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q    <= 3'b010;
      stage2_q    <= 3'b010;
      sclk_prev_q <= 1'b0;
    end else begin
      stage1_q    <= {sclk_i, cs_n_i, mosi_i};
      stage2_q    <= stage1_q;
      sclk_prev_q <= stage2_q[2];
    end
  end

  assign sel_o  = ~stage2_q[1];
  assign rise_o = stage2_q[2] & ~sclk_prev_q;
  assign fall_o = ~stage2_q[2] & sclk_prev_q;
  assign mosi_o = stage2_q[0];
endmodule

// File: rtl/dspi_decoder.sv
module dspi_decoder
  import dspi_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_i,
  input  logic         rise_i,
  input  logic         mosi_i,
  output logic         acc_vld_o,
  output dspi_access_t acc_o,
  output logic         byte_bnd_o,
  output logic         rd_phase_o
);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

  dspi_phase_e         phase_q, phase_d;
  logic [CNT_W-1:0]    bit_q, bit_d;
  logic [BYTE_W-2:0]   sh_q, sh_d;
  logic [HI_W-1:0]     hi_q, hi_d;
  logic                long_q, long_d;
  logic                wr_q, wr_d;
  logic [LONG_AW-1:0]  addr_q, addr_d;
  logic                vld_q, vld_d;
  dspi_access_t        acc_q, acc_d;

  logic [BYTE_W-1:0]   byte_in;
  logic                issue, iss_we;
  logic [LONG_AW-1:0]  iss_addr;

  always_comb begin
    phase_d  = phase_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    hi_d     = hi_q;
    long_d   = long_q;
    wr_d     = wr_q;
    addr_d   = addr_q;
    acc_d    = acc_q;
    issue    = 1'b0;
    iss_we   = 1'b0;
    iss_addr = addr_q;
    byte_in  = {sh_q, mosi_i};
    if (!sel_i) begin
      phase_d = PH_CMD0;
      bit_d   = '0;
    end else if (rise_i) begin
      bit_d = bit_q + CNT_W'(1);
      sh_d  = {sh_q[BYTE_W-3:0], mosi_i};
      if (bit_q == BIT_LAST) begin
        unique case (phase_q)
          PH_CMD0: begin
            if (!byte_in[BYTE_W-1]) begin
              long_d   = 1'b0;
              wr_d     = byte_in[0];
              addr_d   = LONG_AW'(byte_in[SHORT_AW:1]);
              phase_d  = PH_DATA;
              issue    = !byte_in[0];
              iss_addr = addr_d;
            end else begin
              long_d  = 1'b1;
              hi_d    = byte_in[HI_W-1:0];
              phase_d = PH_CMD1;
            end
          end
          PH_CMD1: begin
            addr_d   = {hi_q, byte_in[BYTE_W-1:BYTE_W-3]};
            wr_d     = byte_in[4];
            phase_d  = PH_DATA;
            issue    = !byte_in[4];
            iss_addr = addr_d;
          end
          PH_DATA: begin
            if (wr_q) begin
              issue    = 1'b1;
              iss_we   = 1'b1;
              iss_addr = addr_q;
            end
            if (long_q) begin
              addr_d = addr_q + LONG_AW'(1);
              if (!wr_q) begin
                issue    = 1'b1;
                iss_addr = addr_d;
              end
            end else begin
              phase_d = PH_DONE;
            end
          end
          default: ;
        endcase
      end
    end
    vld_d = issue;
    if (issue) begin
      acc_d.we       = iss_we;
      acc_d.long_sel = long_d;
      acc_d.addr     = iss_addr;
      acc_d.wdata    = byte_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD0;
      bit_q   <= '0;
      sh_q    <= '0;
      hi_q    <= '0;
      long_q  <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      vld_q   <= 1'b0;
      acc_q   <= '0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      long_q  <= long_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      vld_q   <= vld_d;
      hi_q    <= hi_d;
      if (rise_i) sh_q  <= sh_d;
      if (vld_d)  acc_q <= acc_d;
    end
  end

  assign acc_vld_o  = vld_q;
  assign acc_o      = acc_q;
  assign byte_bnd_o = (bit_q == '0);
  assign rd_phase_o = (phase_q == PH_DATA) && !wr_q;
endmodule

// File: rtl/dspi_window.sv
module dspi_window
  import dspi_pkg::*;
#(
  parameter int TX_BASE   = 'h000,
  parameter int TX_DEPTH  = 128,
  parameter int LREG_BASE = 'h200,
  parameter int LREG_CNT  = 64,
  parameter int RX_BASE   = 'h300,
  parameter int RX_DEPTH  = 144
) (
  input  logic               long_sel_i,
  input  logic [LONG_AW-1:0] addr_i,
  output logic               hit_o
);
  localparam int NREG = 3;
  localparam int BASE [NREG] = '{TX_BASE, LREG_BASE, RX_BASE};
  localparam int SPAN [NREG] = '{TX_DEPTH, LREG_CNT, RX_DEPTH};

  logic [NREG-1:0] reg_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    assign reg_hit[g] = (32'(addr_i) >= 32'(BASE[g])) &&
                        (32'(addr_i) <  32'(BASE[g] + SPAN[g]));
  end

  assign hit_o = !long_sel_i || (|reg_hit);
endmodule

// File: rtl/dspi_miso_shift.sv
module dspi_miso_shift
  import dspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              fall_i,
  input  logic              byte_bnd_i,
  input  logic              rd_phase_i,
  input  logic              load_vld_i,
  input  logic [BYTE_W-1:0] load_data_i,
  output logic              miso_o
);
  logic [BYTE_W-1:0] buf_q, buf_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              miso_q, miso_d;

  always_comb begin
    buf_d  = load_vld_i ? load_data_i : buf_q;
    sh_d   = sh_q;
    miso_d = miso_q;
    if (!sel_i) begin
      sh_d   = '0;
      miso_d = 1'b0;
    end else if (fall_i) begin
      if (byte_bnd_i) begin
        miso_d = rd_phase_i ? buf_q[BYTE_W-1] : 1'b0;
        sh_d   = rd_phase_i ? {buf_q[BYTE_W-2:0], 1'b0} : '0;
      end else begin
        miso_d = sh_q[BYTE_W-1];
        sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      sh_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      if (load_vld_i) buf_q <= buf_d;
      sh_q   <= sh_d;
      miso_q <= miso_d;
    end
  end

  assign miso_o = miso_q;
endmodule

// File: rtl/dspi_top.sv
module dspi_top
  import dspi_pkg::*;
#(
  parameter int TX_BASE   = 'h000,
  parameter int TX_DEPTH  = 128,
  parameter int LREG_BASE = 'h200,
  parameter int LREG_CNT  = 64,
  parameter int RX_BASE   = 'h300,
  parameter int RX_DEPTH  = 144
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  output logic               mem_en,
  output logic               mem_we,
  output logic               mem_long,
  output logic [LONG_AW-1:0] mem_addr,
  output logic [BYTE_W-1:0]  mem_wdata,
  input  logic [BYTE_W-1:0]  mem_rdata
);
  logic [1:0]   rst_sync_q;
  logic         rst_n_int;
  logic         sel, rise, fall, mosi_s;
  logic         acc_vld, byte_bnd, rd_phase, hit;
  dspi_access_t acc;
  logic         rd_pend_q, rd_hit_q;
  logic [BYTE_W-1:0] load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  dspi_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n_int),
    .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sel_o(sel), .rise_o(rise), .fall_o(fall), .mosi_o(mosi_s)
  );

  dspi_decoder u_dec (
    .clk(clk), .rst_n(rst_n_int),
    .sel_i(sel), .rise_i(rise), .mosi_i(mosi_s),
    .acc_vld_o(acc_vld), .acc_o(acc),
    .byte_bnd_o(byte_bnd), .rd_phase_o(rd_phase)
  );

  dspi_window #(
    .TX_BASE(TX_BASE), .TX_DEPTH(TX_DEPTH),
    .LREG_BASE(LREG_BASE), .LREG_CNT(LREG_CNT),
    .RX_BASE(RX_BASE), .RX_DEPTH(RX_DEPTH)
  ) u_win (
    .long_sel_i(acc.long_sel), .addr_i(acc.addr), .hit_o(hit)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rd_pend_q <= 1'b0;
      rd_hit_q  <= 1'b0;
    end else begin
      rd_pend_q <= acc_vld && !acc.we;
      if (acc_vld) rd_hit_q <= hit;
    end
  end

  assign load_data = rd_hit_q ? mem_rdata : '0;

  dspi_miso_shift u_miso (
    .clk(clk), .rst_n(rst_n_int),
    .sel_i(sel), .fall_i(fall), .byte_bnd_i(byte_bnd), .rd_phase_i(rd_phase),
    .load_vld_i(rd_pend_q), .load_data_i(load_data), .miso_o(spi_miso)
  );

  assign mem_en    = acc_vld && hit;
  assign mem_we    = acc.we;
  assign mem_long  = acc.long_sel;
  assign mem_addr  = acc.addr;
  assign mem_wdata = acc.wdata;
endmodule

// File: rtl/dspi_checker.sv
module dspi_checker
  import dspi_pkg::*;
#(
  parameter int TX_BASE   = 'h000,
  parameter int TX_DEPTH  = 128,
  parameter int LREG_BASE = 'h200,
  parameter int LREG_CNT  = 64,
  parameter int RX_BASE   = 'h300,
  parameter int RX_DEPTH  = 144
) (
  input logic               clk,
  input logic               rst_n,
  input logic               spi_cs_n,
  input logic               spi_miso,
  input logic               mem_en,
  input logic               mem_long,
  input logic [LONG_AW-1:0] mem_addr
);
  int  a_int;
  logic mapped;
  always_comb begin
    a_int  = 32'(mem_addr);
    mapped = !mem_long ||
             (a_int >= TX_BASE   && a_int < TX_BASE + TX_DEPTH) ||
             (a_int >= LREG_BASE && a_int < LREG_BASE + LREG_CNT) ||
             (a_int >= RX_BASE   && a_int < RX_BASE + RX_DEPTH);
  end

  // R7: no strobe reaches an unmapped long address
  p_mapped_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mapped);

  // R1: short accesses keep the upper address bits clear
  p_short_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_long) |-> (mem_addr[LONG_AW-1:SHORT_AW] == '0));

  // R9: every strobe lasts a single clock
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> !mem_en);

  // R8: MISO settles to 0 once chip select has been high for a while
  p_miso_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_miso);
endmodule

bind dspi_top dspi_checker #(
  .TX_BASE(TX_BASE), .TX_DEPTH(TX_DEPTH),
  .LREG_BASE(LREG_BASE), .LREG_CNT(LREG_CNT),
  .RX_BASE(RX_BASE), .RX_DEPTH(RX_DEPTH)
) u_dspi_checker (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .mem_en(mem_en), .mem_long(mem_long), .mem_addr(mem_addr)
);

// File: tb/test_dspi_top.sv
module test_dspi_top;
  localparam int HALF = 10;

  logic       clk, rst_n, sclk, cs_n, mosi, miso;
  logic       mem_en, mem_we, mem_long;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  int cyc = 0;

  logic [7:0] sm [64];
  logic [7:0] lm [1024];
  int gs [64];
  int gl [1024];
  int exp_wr [$];
  logic [7:0] txb [16];
  logic [7:0] rxb [16];

  dspi_top i_dspi_top (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .mem_en(mem_en), .mem_we(mem_we),
    .mem_long(mem_long), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic bit mapped_long(int a);
    return (a < 128) || (a >= 512 && a < 576) || (a >= 768 && a < 912);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // storage behind the memory port, one-cycle read latency (R9)
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (mem_long) lm[mem_addr] <= mem_wdata;
        else          sm[mem_addr[5:0]] <= mem_wdata;
      end else begin
        mem_rdata <= mem_long ? lm[mem_addr] : sm[mem_addr[5:0]];
      end
    end
  end

  // per-clock reference comparison of the memory port
  always @(negedge clk) begin
    if (rst_n && mem_en) begin
      check(!mem_long || mapped_long(int'(mem_addr)), "R7 strobe on unmapped address",
            int'(mem_addr), 0);
      if (mem_we) begin
        if (exp_wr.size() == 0) begin
          check(0, "R2/R6 unexpected write", int'({mem_long, mem_addr, mem_wdata}), 0);
        end else begin
          int e;
          e = exp_wr.pop_front();
          check(e == int'({mem_long, mem_addr, mem_wdata}), "R4 write order/content",
                int'({mem_long, mem_addr, mem_wdata}), e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(int n);
    cs_n = 0;
    wait_clk(HALF);
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = txb[b][i];
        wait_clk(HALF);
        rxb[b][i] = miso;   // host samples just before rising edge (R8)
        sclk = 1;
        wait_clk(HALF);
        sclk = 0;
      end
    end
    wait_clk(HALF);
    cs_n = 1;
    wait_clk(3 * HALF);
  endtask

  task automatic partial_frame(logic [15:0] pat, int nbits);
    cs_n = 0;
    wait_clk(HALF);
    for (int i = 15; i > 15 - nbits; i--) begin
      mosi = pat[i];
      wait_clk(HALF);
      sclk = 1;
      wait_clk(HALF);
      sclk = 0;
    end
    wait_clk(HALF);
    cs_n = 1;
    wait_clk(3 * HALF);
  endtask

  task automatic short_write(int a, int d, bit extra);
    txb[0] = {1'b0, a[5:0], 1'b1};
    txb[1] = d[7:0];
    txb[2] = 8'h5A;
    exp_wr.push_back(int'({1'b0, 10'(a), d[7:0]}));
    gs[a] = d & 255;
    run_frame(extra ? 3 : 2);
  endtask

  task automatic short_read(int a, string req);
    txb[0] = {1'b0, a[5:0], 1'b0};
    txb[1] = 8'h00;
    run_frame(2);
    check(rxb[0] == 8'h00, "R1 MISO quiet during command", int'(rxb[0]), 0);
    check(int'(rxb[1]) == gs[a], req, int'(rxb[1]), gs[a]);
  endtask

  task automatic long_write(int a, int n, int seed);
    logic [15:0] cmd;
    cmd = {1'b1, 10'(a), 1'b1, 4'b0000};
    txb[0] = cmd[15:8];
    txb[1] = cmd[7:0];
    for (int i = 0; i < n; i++) begin
      int aa, d;
      aa = (a + i) & 1023;
      d = (seed + i * 17) & 255;
      txb[2 + i] = d[7:0];
      if (mapped_long(aa)) begin
        exp_wr.push_back(int'({1'b1, 10'(aa), d[7:0]}));
        gl[aa] = d;
      end
    end
    run_frame(2 + n);
  endtask

  task automatic long_read(int a, int n, string req);
    logic [15:0] cmd;
    cmd = {1'b1, 10'(a), 1'b0, 4'b1010};
    txb[0] = cmd[15:8];
    txb[1] = cmd[7:0];
    for (int i = 0; i < n; i++) txb[2 + i] = 8'h00;
    run_frame(2 + n);
    for (int i = 0; i < n; i++) begin
      int aa, e;
      aa = (a + i) & 1023;
      e = mapped_long(aa) ? gl[aa] : 0;
      check(int'(rxb[2 + i]) == e, req, int'(rxb[2 + i]), e);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      sm[i] = 8'((i * 13 + 5) & 255);
      gs[i] = (i * 13 + 5) & 255;
    end
    for (int i = 0; i < 1024; i++) begin
      lm[i] = 8'((i * 29 + 7) & 255);
      gl[i] = (i * 29 + 7) & 255;
    end
    mem_rdata = 8'h00;
    rst_n = 0; cs_n = 1; sclk = 0; mosi = 0;
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);

    check(miso == 1'b0, "R8 MISO low after reset", int'(miso), 0);
    check(mem_en == 1'b0, "R9 no strobe after reset", int'(mem_en), 0);

    short_read(0, "R1 short read addr 0");
    short_write(5, 'hA7, 0);
    short_read(5, "R2 short write then read");
    short_write(63, 'h3C, 1);                // stray third byte
    short_read(63, "R2 short write with extra byte");
    short_read(62, "R2 neighbour untouched by extra byte");

    long_write('h200, 3, 'h11);
    long_read('h200, 3, "R3 R5 long register burst read");
    long_read('h300, 5, "R5 receive window burst read");

    long_write('h07E, 4, 'h40);              // crosses out of transmit window
    long_read('h07E, 4, "R7 burst across window edge");
    long_read('h150, 2, "R7 unmapped gap reads zero");

    long_write('h3FF, 2, 'h90);              // wraps to 0x000
    long_read('h3FF, 2, "R4 write wrap to 0x000");

    partial_frame(16'hA5FF, 5);              // R6: cut in first byte
    short_read(5, "R6 decoder reset after partial byte");
    partial_frame(16'hC5FF, 11);             // R6: cut in second long byte
    short_read(7, "R6 short command after aborted long");
    long_read('h001, 1, "R6 R3 long read after abort");

    check(exp_wr.size() == 0, "R4 all expected writes seen", exp_wr.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule